// File: doc/BRIEF.md
# Wallace Tree Unsigned Multiplier

This block multiplies two unsigned operands of `N` bits each and returns the full `2N`-bit product in the same cycle. It has no clock or state. Every operand bit pair is ANDed to form a matrix of partial-product bits, one column per bit weight. Layers of counters then shrink that matrix in parallel. A 3:2 counter (full adder) turns three bits of a column into a sum in that column and a carry into the next column up. A 2:2 counter (half adder) handles a column that holds two bits and would otherwise overflow.

The number of layers, and which counters sit in which column, are computed at elaboration from `N`. Inside a layer, every counter reads only bits that the previous layer produced. Reduction stops once no column is taller than two bits. The two remaining rows then go to one carry-propagate adder, and that adder is the only place where a carry runs along the word. With the default `N = 4`, the schedule needs two counter layers before the final adder.

The block is meant to sit inside a datapath where a wider pipeline supplies the register stages around it.

Top module: `wallace_mult`

## Requirements
- R1: `prod_o` equals the unsigned product of `x_i` and `y_i` for every operand pair, with all `2N` bits significant.
- R2: If either operand is zero, `prod_o` is zero.
- R3: If one operand is 1, `prod_o` equals the other operand, zero-extended to `2N` bits.
- R4: With both operands all ones, `prod_o` equals `(2^N-1)^2`, which has its most significant bit set (0xE1 for N = 4).
- R5: If `x_i = 2^a` and `y_i = 2^b`, `prod_o` has exactly one bit set, at position `a+b`. This shows that every carry lands in the correct column.
- R6: Swapping the two operands does not change `prod_o`.
- R7: Bit 0 of `prod_o` equals the AND of bit 0 of each operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | Unsigned multiplicand |
| y_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Unsigned product, combinational |

## Verification
Every one of the 256 operand pairs for the default width is applied and compared against a shift-and-add reference, so no counter placement escapes R1. Random pairs from a fixed seed then repeat the comparison and also check that swapping the operands changes nothing. Directed cases separate distinct fault classes:
- Zero and unit operands catch stuck or misrouted matrix bits.
- Single-bit operands at every pair of positions catch a carry sent into the wrong column.
- The all-ones pair fills every column to its tallest, so it loads every counter at once and drives a carry into the top product bit.

// File: rtl/wallace_plan_pkg.sv
// Elaboration-time planner for the counter tree. The functions replay the
// reduction of the partial-product column heights stage by stage, so the
// wiring in the top module can derive every count and offset from N alone.
// Assumes 2*N <= MAXW.
package wallace_plan_pkg;

    localparam int MAXW = 128;

    // Number of AND terms whose weight is column c in an n-by-n product.
    function automatic int init_height(input int n, input int c);
        int k;
        k = 0;
        for (int i = 0; i < n; i++)
            if ((c - i >= 0) && (c - i < n)) k++;
        return k;
    endfunction

    // Query the schedule. what: 0 = column height at stage s,
    // 1 = full adders placed there, 2 = half adders placed there,
    // 3 = tallest column entering stage s.
    function automatic int plan_query(input int n, input int s, input int c, input int what);
        int h  [MAXW];
        int nh [MAXW];
        int fa;
        int ha;
        int cin;
        int mx;
        for (int k = 0; k < MAXW; k++) begin
            h[k]  = (k < 2 * n) ? init_height(n, k) : 0;
            nh[k] = 0;
        end
        for (int st = 0; st <= s; st++) begin
            if (st == s && what == 3) begin
                mx = 0;
                for (int k = 0; k < 2 * n; k++)
                    if (h[k] > mx) mx = h[k];
                return mx;
            end
            cin = 0;
            for (int k = 0; k < 2 * n; k++) begin
                fa = 0;
                ha = 0;
                if (h[k] >= 3) begin
                    fa = h[k] / 3;
                    ha = (h[k] % 3 == 2) ? 1 : 0;
                end else if (h[k] == 2 && cin > 0) begin
                    ha = 1;
                end
                if (st == s && k == c) begin
                    if (what == 0) return h[k];
                    if (what == 1) return fa;
                    return ha;
                end
                nh[k] = h[k] - 2 * fa - ha + cin;
                cin   = fa + ha;
            end
            for (int k = 0; k < MAXW; k++) h[k] = nh[k];
        end
        return 0;
    endfunction

    // Flat bit offset of column c within stage s.
    function automatic int plan_offset(input int n, input int s, input int c);
        int o;
        o = 0;
        for (int k = 0; k < c; k++) o += plan_query(n, s, k, 0);
        return o;
    endfunction

    // Total bits alive in stage s.
    function automatic int plan_total(input int n, input int s);
        return plan_offset(n, s, 2 * n);
    endfunction

    // Number of counter layers until no column exceeds two bits.
    function automatic int plan_stages(input int n);
        for (int s = 0; s < 64; s++)
            if (plan_query(n, s, 0, 3) <= 2) return s;
        return 64;
    endfunction

endpackage

// File: rtl/wt_pp_gen.sv
// Partial-product generator. Emits every x[i]&y[j] bit, grouped by weight
// i+j, lowest column first, into one flat vector laid out as the planner
// expects. Assumes T equals the planner total for stage 0.
module wt_pp_gen
    import wallace_plan_pkg::*;
#(
    parameter int N = 4,
    parameter int T = 16
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    output logic [T-1:0] pp_o
);
    localparam int W = 2 * N;

    // One AND gate per operand bit pair, placed in its weight column.
    for (genvar c = 0; c < W; c++) begin : g_col
        localparam int H  = plan_query(N, 0, c, 0);
        localparam int OF = plan_offset(N, 0, c);
        localparam int LO = (c > N - 1) ? c - N + 1 : 0;
        for (genvar k = 0; k < H; k++) begin : g_bit
            assign pp_o[OF + k] = x_i[LO + k] & y_i[c - LO - k];
        end
    end
endmodule

// File: rtl/wt_fa.sv
// 3:2 counter. Three bits of equal weight in; a sum of that weight and a
// carry of the next weight out. No assumptions.
module wt_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // Parity gives the sum, majority gives the carry.
    assign s_o = a_i ^ b_i ^ c_i;
    assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/wt_ha.sv
// 2:2 counter. Two bits of equal weight in; sum and next-weight carry out.
module wt_ha (
    input  logic a_i,
    input  logic b_i,
    output logic s_o,
    output logic c_o
);
    // XOR for the sum, AND for the carry.
    assign s_o = a_i ^ b_i;
    assign c_o = a_i & b_i;
endmodule

// File: rtl/wt_cpa.sv
// Final carry-propagate adder for the two surviving rows. The result is
// taken modulo 2^W; the carry out of the top bit is never needed because
// the product always fits in W bits.
module wt_cpa #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] cy;

    // Carry chain: generate or propagate from the bit below.
    always_comb begin
        cy[0] = 1'b0;
        for (int i = 1; i < W; i++)
            cy[i] = (a_i[i-1] & b_i[i-1]) | ((a_i[i-1] ^ b_i[i-1]) & cy[i-1]);
    end

    // Sum bits from the local propagate and the incoming carry.
    assign sum_o = a_i ^ b_i ^ cy;
endmodule

// File: rtl/wallace_mult.sv
// Wallace tree unsigned multiplier, top level. Builds the AND matrix,
// reduces it with planner-scheduled layers of 3:2 and 2:2 counters, and
// adds the last two rows. Purely combinational. Inside each layer the
// column bits are packed as [sums | pass-through | carries from below].
module wallace_mult
    import wallace_plan_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]   x_i,
    input  logic [N-1:0]   y_i,
    output logic [2*N-1:0] prod_o
);
    localparam int W  = 2 * N;
    localparam int S  = plan_stages(N);
    localparam int T0 = plan_total(N, 0);
    localparam int TF = plan_total(N, S);

    logic [T0-1:0] pp;
    logic [TF-1:0] fv;
    logic [W-1:0]  row_a;
    logic [W-1:0]  row_b;

    wt_pp_gen #(.N(N), .T(T0)) u_pp (
        .x_i  (x_i),
        .y_i  (y_i),
        .pp_o (pp)
    );

    // One counter layer per stage; each layer reads only the previous one.
    for (genvar s = 0; s < S; s++) begin : g_stg
        localparam int TI = plan_total(N, s);
        localparam int TO = plan_total(N, s + 1);
        logic [TI-1:0] v;
        logic [TO-1:0] nv;

        if (s == 0) begin : g_src0
            assign v = pp;
        end else begin : g_srcn
            assign v = g_stg[s-1].nv;
        end

        for (genvar c = 0; c < W; c++) begin : g_col
            localparam int H   = plan_query(N, s, c, 0);
            localparam int NF  = plan_query(N, s, c, 1);
            localparam int NH  = plan_query(N, s, c, 2);
            localparam int IO  = plan_offset(N, s, c);
            localparam int OO  = plan_offset(N, s + 1, c);
            localparam int NP  = H - 3 * NF - 2 * NH;
            localparam int H1  = plan_query(N, s, c + 1, 0);
            localparam int NF1 = plan_query(N, s, c + 1, 1);
            localparam int NH1 = plan_query(N, s, c + 1, 2);
            localparam int CB  = plan_offset(N, s + 1, c + 1) + H1 - 2 * NF1 - NH1;

            for (genvar f = 0; f < NF; f++) begin : g_fa
                if (c < W - 1) begin : g_in
                    wt_fa u_fa (
                        .a_i (v[IO + 3*f]),
                        .b_i (v[IO + 3*f + 1]),
                        .c_i (v[IO + 3*f + 2]),
                        .s_o (nv[OO + f]),
                        .c_o (nv[CB + f])
                    );
                end else begin : g_top
                    logic drop;
                    wt_fa u_fa (
                        .a_i (v[IO + 3*f]),
                        .b_i (v[IO + 3*f + 1]),
                        .c_i (v[IO + 3*f + 2]),
                        .s_o (nv[OO + f]),
                        .c_o (drop)
                    );
                end
            end

            for (genvar k = 0; k < NH; k++) begin : g_ha
                if (c < W - 1) begin : g_in
                    wt_ha u_ha (
                        .a_i (v[IO + 3*NF + 2*k]),
                        .b_i (v[IO + 3*NF + 2*k + 1]),
                        .s_o (nv[OO + NF + k]),
                        .c_o (nv[CB + NF + k])
                    );
                end else begin : g_top
                    logic drop;
                    wt_ha u_ha (
                        .a_i (v[IO + 3*NF + 2*k]),
                        .b_i (v[IO + 3*NF + 2*k + 1]),
                        .s_o (nv[OO + NF + k]),
                        .c_o (drop)
                    );
                end
            end

            for (genvar p = 0; p < NP; p++) begin : g_pass
                assign nv[OO + NF + NH + p] = v[IO + 3*NF + 2*NH + p];
            end
        end
    end

    // Hand the last layer (or the raw matrix, if nothing needed reducing) on.
    if (S == 0) begin : g_fin0
        assign fv = pp;
    end else begin : g_finn
        assign fv = g_stg[S-1].nv;
    end

    // Split each column of at most two bits into the two adder rows.
    for (genvar c = 0; c < W; c++) begin : g_row
        localparam int HF = plan_query(N, S, c, 0);
        localparam int OF = plan_offset(N, S, c);
        if (HF >= 1) begin : g_a
            assign row_a[c] = fv[OF];
        end else begin : g_az
            assign row_a[c] = 1'b0;
        end
        if (HF >= 2) begin : g_b
            assign row_b[c] = fv[OF + 1];
        end else begin : g_bz
            assign row_b[c] = 1'b0;
        end
    end

    wt_cpa #(.W(W)) u_cpa (
        .a_i   (row_a),
        .b_i   (row_b),
        .sum_o (prod_o)
    );
endmodule

// File: rtl/wallace_mult_chk.sv
// Checker for wallace_mult. Holds immediate assertions over the operands,
// the two rows entering the final adder and the product. It is attached
// through the bind below and assumes nothing beyond stable operand values.
module wallace_mult_chk #(
    parameter int N = 4
) (
    input logic [N-1:0]   x_i,
    input logic [N-1:0]   y_i,
    input logic [2*N-1:0] row_a,
    input logic [2*N-1:0] row_b,
    input logic [2*N-1:0] prod_o
);
    localparam int W = 2 * N;

    logic [W-1:0] wide_x;
    logic [W-1:0] wide_y;
    logic [W-1:0] rows_sum;

    // Zero-extended operands and the row total, for the comparisons below.
    always_comb begin
        wide_x   = W'(x_i);
        wide_y   = W'(y_i);
        rows_sum = row_a + row_b;
    end

    // Properties on the settled combinational outputs.
    always_comb begin
        if (!$isunknown({x_i, y_i, row_a, row_b, prod_o})) begin
            // R1
            product_match_chk: assert (prod_o == wide_x * wide_y);
            // R1
            rows_total_chk: assert (rows_sum == prod_o);
            // R2
            zero_operand_chk: assert (!((x_i == '0) || (y_i == '0)) || (prod_o == '0));
            // R3
            unit_operand_chk: assert (!(y_i == N'(1)) || (prod_o == wide_x));
            // R7
            low_bit_chk: assert (prod_o[0] == (x_i[0] & y_i[0]));
        end
    end
endmodule

bind wallace_mult wallace_mult_chk #(.N(N)) u_chk (
    .x_i    (x_i),
    .y_i    (y_i),
    .row_a  (row_a),
    .row_b  (row_b),
    .prod_o (prod_o)
);

// File: tb/wallace_mult_tb.sv
// Self-checking bench for wallace_mult: exhaustive, random and directed.
module wallace_mult_tb;
    localparam int N = 4;
    localparam int W = 2 * N;

    logic         clk;
    logic         rst_n;
    logic [N-1:0] x_i;
    logic [N-1:0] y_i;
    logic [W-1:0] prod_o;
    int           n_checks;
    int           n_fails;
    bit           finished;

    wallace_mult #(.N(N)) u_dut (
        .x_i    (x_i),
        .y_i    (y_i),
        .prod_o (prod_o)
    );

    // 100 MHz clock, used only for the watchdog's timebase.
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Shift-and-add reference product.
    function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [W-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++)
            if (b[i]) acc = acc + (W'(a) << i);
        return acc;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s x=%0d y=%0d actual=0x%0h expected=0x%0h", req, x_i, y_i, act, exp);
        end
    endtask

    // Drive operands away from clock edges and let the logic settle.
    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        x_i = a;
        y_i = b;
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] p1;
        n_checks = 0;
        n_fails  = 0;
        finished = 1'b0;
        rst_n    = 1'b0;
        x_i      = '0;
        y_i      = '0;
        void'($urandom(32'd1234));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: zero operands give zero (R2).
        apply('0, '0);
        check("R2 idle", prod_o, '0);

        // R1: every operand pair against the reference.
        for (int a = 0; a < (1 << N); a++)
            for (int b = 0; b < (1 << N); b++) begin
                apply(N'(a), N'(b));
                check("R1 exhaustive", prod_o, ref_mul(N'(a), N'(b)));
            end

        // R2: zero on either side.
        for (int a = 0; a < (1 << N); a++) begin
            apply(N'(a), '0);
            check("R2 y zero", prod_o, '0);
            apply('0, N'(a));
            check("R2 x zero", prod_o, '0);
        end

        // R3: unit operand on either side.
        for (int a = 0; a < (1 << N); a++) begin
            apply(N'(a), N'(1));
            check("R3 y one", prod_o, W'(a));
            apply(N'(1), N'(a));
            check("R3 x one", prod_o, W'(a));
        end

        // R4: both all ones, top product bit set.
        apply('1, '1);
        check("R4 all ones", prod_o, W'(((1 << N) - 1) * ((1 << N) - 1)));
        check("R4 msb", W'(prod_o[W-1]), W'(1));

        // R5: single-bit operands place one bit at a+b.
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++) begin
                apply(N'(1) << a, N'(1) << b);
                check("R5 one-hot", prod_o, W'(1) << (a + b));
            end

        // R6 and R7 with random operands; R1 again on each.
        for (int t = 0; t < 300; t++) begin
            logic [N-1:0] ra;
            logic [N-1:0] rb;
            ra = N'($urandom);
            rb = N'($urandom);
            apply(ra, rb);
            p1 = prod_o;
            check("R1 random", p1, ref_mul(ra, rb));
            check("R7 low bit", W'(p1[0]), W'(ra[0] & rb[0]));
            apply(rb, ra);
            check("R6 swapped", prod_o, p1);
        end

        finish_run();
    end
endmodule